// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns software-raised interrupt requests between up to eight processors into per-target, per-interrupt pending state. A processor writes a trigger word that names one of sixteen software interrupts and picks its targets with a filter mode. For every chosen target, the block records which processor raised that interrupt. The record is an 8-bit source bitmap kept for each pair of target and interrupt. A pair is pending while any bit of its bitmap is set.

A set/clear window port lets a processor read and edit its own bitmaps four interrupts at a time. The port is used to save and restore state, and it raises a one-cycle change pulse only when a write really alters something. Each target has a valid/ready delivery port. Through it a downstream consumer drains the recorded sources one per cycle. When the last source of a pair drains, that pair stops pending.

Top module: `sgi_dispatch`

## Requirements
- R1: A trigger write takes the interrupt number from bits [3:0], the filter mode from bits [25:24] and the target list from bits [23:16]. In mode 0 the targets are exactly the list bits. A mode-0 write with an all-zero list changes nothing.
- R2: In mode 1 the targets are the processors numbered below `online_cnt`, except the requester. The list bits are ignored.
- R3: In mode 2 the only target is the requester itself.
- R4: Mode 3 is reserved. A trigger write in mode 3 changes no state.
- R5: For each selected target, the bit of the requester (bit r for requester r) is set in that target's bitmap for the named interrupt. `pend` bit t*16+s is the OR of the bitmap of target t and interrupt s, and it is visible in the cycle after the trigger write.
- R6: `win_rdata` returns four bitmaps of processor `win_cpu`. Byte k holds interrupt b+k, where b is `win_offset` rounded down to a multiple of 4. The value does not depend on `win_set`.
- R7: A window write with `win_set`=1 ORs each byte into the matching bitmap. With `win_set`=0, it clears the bits that are set in each byte.
- R8: `win_changed` is high for exactly the one cycle after a window write that altered at least one bitmap bit. It stays low after a window write that altered nothing.
- R9: Each target offers its lowest-numbered pending interrupt, and within it the lowest-numbered source. A handshake with `dlv_ready` clears that one source bit. Once the bitmap is empty, the pair stops pending and `dlv_valid` drops.
- R10: While `rst_n` is low, all bitmaps are empty, so `pend` and `dlv_valid` are zero.
- R11: When one cycle both sets and clears the same bitmap bit (by trigger or set window against clear window or delivery), the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| online_cnt | input | 4 | Number of online processors, used by filter mode 1 |
| trig_we | input | 1 | Trigger word write strobe |
| trig_req | input | 3 | Requesting processor of the trigger write |
| trig_wdata | input | 32 | Trigger word |
| win_valid | input | 1 | Window access valid |
| win_write | input | 1 | Window access is a write |
| win_set | input | 1 | 1 selects the set window, 0 the clear window |
| win_cpu | input | 3 | Processor whose bitmaps the window addresses |
| win_offset | input | 4 | Byte offset of the window word |
| win_wdata | input | 32 | Window write data, one source byte per interrupt |
| win_rdata | output | 32 | Window read data |
| win_changed | output | 1 | One-cycle pulse after a window write that changed state |
| pend | output | 128 | Pending flag per target (t*16) and interrupt (+s) |
| dlv_valid | output | 8 | Per target: a source is offered |
| dlv_ready | input | 8 | Per target: consumer accepts the offer |
| dlv_sgi | output | 32 | Per target, 4 bits each: offered interrupt number |
| dlv_src | output | 24 | Per target, 3 bits each: offered source processor |

## Verification
The assertions check five things on every cycle. An offered delivery always points at a pending pair. A pending flag never rises without a trigger or set-window write one cycle earlier. A reserved-mode trigger raises nothing. A self-targeted trigger always lands. The change pulse only ever follows a window write. The bench scenarios are the only place to show the exact decoding of the target list and of the all-others mask against `online_cnt`. They also show the window byte layout, the change pulse staying low on writes that alter nothing, the lowest-first delivery order, and set winning over a clear in the same cycle.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  // Trigger word field positions
  localparam int TRIG_SGI_LSB  = 0;
  localparam int TRIG_LIST_LSB = 16;
  localparam int TRIG_MODE_LSB = 24;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } filt_mode_e;

endpackage

// File: rtl/sgi_pick.sv
// Lowest-index set bit finder
module sgi_pick #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/sgi_trig_decode.sv
// Trigger word decode: target mask, interrupt number, requester one-hot
module sgi_trig_decode
  import sgi_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int CPU_W = 3,
  parameter int SGI_W = 4
) (
  input  logic             trig_we,
  input  logic [CPU_W-1:0] req_id,
  input  logic [31:0]      trig_wdata,
  input  logic [CPU_W:0]   online_cnt,
  output logic [NCPU-1:0]  tgt_mask,
  output logic [SGI_W-1:0] sgi,
  output logic [NCPU-1:0]  src_oh
);

  filt_mode_e      mode;
  logic [NCPU-1:0] list_bits;
  logic [NCPU-1:0] online_mask;
  logic [NCPU-1:0] sel;
  logic            unused_fields;

  assign unused_fields = ^{trig_wdata[TRIG_LIST_LSB-1:SGI_W], trig_wdata[31:TRIG_MODE_LSB+2]};

  assign sgi = trig_wdata[TRIG_SGI_LSB +: SGI_W];

  always_comb begin
    mode      = filt_mode_e'(trig_wdata[TRIG_MODE_LSB +: 2]);
    list_bits = trig_wdata[TRIG_LIST_LSB +: NCPU];
    src_oh    = NCPU'(1) << req_id;
    for (int i = 0; i < NCPU; i++) begin
      online_mask[i] = ((CPU_W+1)'(i) < online_cnt);
    end
    unique case (mode)
      FLT_LIST:   sel = list_bits;
      FLT_OTHERS: sel = online_mask & ~src_oh;
      FLT_SELF:   sel = src_oh;
      default:    sel = '0;
    endcase
    tgt_mask = trig_we ? sel : '0;
  end

endmodule

// File: rtl/sgi_src_bank.sv
// Source bitmaps of one target: NSGI bitmaps of NCPU bits each
module sgi_src_bank #(
  parameter int NCPU  = 8,
  parameter int NSGI  = 16,
  parameter int CPU_W = 3,
  parameter int SGI_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_hit,
  input  logic [SGI_W-1:0] trig_sgi,
  input  logic [NCPU-1:0]  src_oh,
  input  logic             win_we,
  input  logic             win_set,
  input  logic [SGI_W-1:0] win_base,
  input  logic [31:0]      win_wdata,
  input  logic             dlv_ready,
  output logic [NSGI-1:0]  pend,
  output logic [31:0]      win_rd,
  output logic             win_eff,
  output logic             dlv_valid,
  output logic [SGI_W-1:0] dlv_sgi,
  output logic [CPU_W-1:0] dlv_src
);

  localparam int WIN_SLOTS = 4;

  logic [NCPU-1:0] src_q [NSGI];
  logic [NCPU-1:0] src_d [NSGI];
  logic [NCPU-1:0] set_m [NSGI];
  logic [NCPU-1:0] clr_m [NSGI];
  logic [NCPU-1:0] wbyte [NSGI];
  logic [NSGI-1:0] in_win;
  logic [NCPU-1:0] sel_map;
  logic [NCPU-1:0] pick_oh;
  logic            src_any;
  logic            accept;
  logic            upd_en;

  always_comb begin
    for (int s = 0; s < NSGI; s++) pend[s] = |src_q[s];
  end

  sgi_pick #(.W(NSGI), .IW(SGI_W)) u_pick_sgi (
    .vec (pend),
    .any (dlv_valid),
    .idx (dlv_sgi)
  );

  assign sel_map = src_q[dlv_sgi];

  sgi_pick #(.W(NCPU), .IW(CPU_W)) u_pick_src (
    .vec (sel_map),
    .any (src_any),
    .idx (dlv_src)
  );

  assign pick_oh = NCPU'(1) << dlv_src;
  assign accept  = dlv_valid && src_any && dlv_ready;
  assign upd_en  = tgt_hit || win_we || accept;

  // Window read: four consecutive bitmaps from the aligned base
  always_comb begin
    win_rd = '0;
    for (int k = 0; k < WIN_SLOTS; k++) begin
      win_rd[8*k +: NCPU] = src_q[win_base + SGI_W'(k)];
    end
  end

  // Next state: clear terms first, set terms last so a set wins
  always_comb begin
    win_eff = 1'b0;
    for (int s = 0; s < NSGI; s++) begin
      in_win[s] = win_we && ((SGI_W'(s) >> 2) == (win_base >> 2));
      wbyte[s]  = win_wdata[8*(s%WIN_SLOTS) +: NCPU];
      set_m[s]  = (tgt_hit && (trig_sgi == SGI_W'(s))) ? src_oh : '0;
      clr_m[s]  = (accept && (dlv_sgi == SGI_W'(s))) ? pick_oh : '0;
      if (in_win[s]) begin
        if (win_set) begin
          set_m[s] = set_m[s] | wbyte[s];
          if ((src_q[s] & wbyte[s]) != wbyte[s]) win_eff = 1'b1;
        end else begin
          clr_m[s] = clr_m[s] | wbyte[s];
          if (|(src_q[s] & wbyte[s])) win_eff = 1'b1;
        end
      end
      src_d[s] = (src_q[s] & ~clr_m[s]) | set_m[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSGI; s++) src_q[s] <= '0;
    end else if (upd_en) begin
      for (int s = 0; s < NSGI; s++) src_q[s] <= src_d[s];
    end
  end

endmodule

// File: rtl/sgi_dispatch.sv
// Top: trigger decode, one source bank per target, window mux, change pulse
module sgi_dispatch #(
  parameter int NCPU  = 8,
  parameter int NSGI  = 16,
  parameter int CPU_W = $clog2(NCPU),
  parameter int SGI_W = $clog2(NSGI)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CPU_W:0]          online_cnt,
  input  logic                    trig_we,
  input  logic [CPU_W-1:0]        trig_req,
  input  logic [31:0]             trig_wdata,
  input  logic                    win_valid,
  input  logic                    win_write,
  input  logic                    win_set,
  input  logic [CPU_W-1:0]        win_cpu,
  input  logic [SGI_W-1:0]        win_offset,
  input  logic [31:0]             win_wdata,
  output logic [31:0]             win_rdata,
  output logic                    win_changed,
  output logic [NCPU*NSGI-1:0]    pend,
  output logic [NCPU-1:0]         dlv_valid,
  input  logic [NCPU-1:0]         dlv_ready,
  output logic [NCPU*SGI_W-1:0]   dlv_sgi,
  output logic [NCPU*CPU_W-1:0]   dlv_src
);

  logic [NCPU-1:0]  tgt_mask;
  logic [SGI_W-1:0] trig_sgi;
  logic [NCPU-1:0]  src_oh;
  logic [SGI_W-1:0] win_base;
  logic [31:0]      bank_rd [NCPU];
  logic [NCPU-1:0]  bank_eff;
  logic             chg_d;
  logic             chg_q;
  logic             unused_off;

  assign unused_off = ^win_offset[1:0];
  assign win_base   = {win_offset[SGI_W-1:2], 2'b00};

  sgi_trig_decode #(.NCPU(NCPU), .CPU_W(CPU_W), .SGI_W(SGI_W)) u_decode (
    .trig_we    (trig_we),
    .req_id     (trig_req),
    .trig_wdata (trig_wdata),
    .online_cnt (online_cnt),
    .tgt_mask   (tgt_mask),
    .sgi        (trig_sgi),
    .src_oh     (src_oh)
  );

  for (genvar t = 0; t < NCPU; t++) begin : g_bank
    logic             win_we_t;
    logic [NSGI-1:0]  pend_t;
    logic [SGI_W-1:0] sgi_t;
    logic [CPU_W-1:0] src_t;

    assign win_we_t = win_valid && win_write && (win_cpu == CPU_W'(t));

    sgi_src_bank #(.NCPU(NCPU), .NSGI(NSGI), .CPU_W(CPU_W), .SGI_W(SGI_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgt_hit   (tgt_mask[t]),
      .trig_sgi  (trig_sgi),
      .src_oh    (src_oh),
      .win_we    (win_we_t),
      .win_set   (win_set),
      .win_base  (win_base),
      .win_wdata (win_wdata),
      .dlv_ready (dlv_ready[t]),
      .pend      (pend_t),
      .win_rd    (bank_rd[t]),
      .win_eff   (bank_eff[t]),
      .dlv_valid (dlv_valid[t]),
      .dlv_sgi   (sgi_t),
      .dlv_src   (src_t)
    );

    assign pend[t*NSGI +: NSGI]     = pend_t;
    assign dlv_sgi[t*SGI_W +: SGI_W] = sgi_t;
    assign dlv_src[t*CPU_W +: CPU_W] = src_t;
  end

  assign win_rdata = bank_rd[win_cpu];

  always_comb begin
    chg_d = |bank_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_d;
  end

  assign win_changed = chg_q;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU  = 8,
  parameter int NSGI  = 16,
  parameter int CPU_W = 3,
  parameter int SGI_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trig_we,
  input logic [CPU_W-1:0]      trig_req,
  input logic [SGI_W-1:0]      trig_sgi,
  input logic [1:0]            trig_mode,
  input logic                  win_valid,
  input logic                  win_write,
  input logic                  win_set,
  input logic                  win_changed,
  input logic [NCPU*NSGI-1:0]  pend,
  input logic [NCPU-1:0]       dlv_valid,
  input logic [NCPU*SGI_W-1:0] dlv_sgi
);

  logic [CPU_W+SGI_W-1:0] self_idx;
  assign self_idx = {trig_req, trig_sgi};

  assert_pulse_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_changed |-> $past(win_valid && win_write));

  assert_rise_needs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~$past(pend))) |-> $past(trig_we || (win_valid && win_write && win_set)));

  assert_rsvd_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_mode == 2'd3 && !(win_valid && win_write)) |=> ((pend & ~$past(pend)) == '0));

  assert_self_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_mode == 2'd2) |=> pend[$past(self_idx)]);

  for (genvar t = 0; t < NCPU; t++) begin : g_offer
    assert_offer_is_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid[t] |-> pend[{CPU_W'(t), dlv_sgi[t*SGI_W +: SGI_W]}]);
  end

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI), .CPU_W(CPU_W), .SGI_W(SGI_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_we     (trig_we),
  .trig_req    (trig_req),
  .trig_sgi    (trig_wdata[SGI_W-1:0]),
  .trig_mode   (trig_wdata[25:24]),
  .win_valid   (win_valid),
  .win_write   (win_write),
  .win_set     (win_set),
  .win_changed (win_changed),
  .pend        (pend),
  .dlv_valid   (dlv_valid),
  .dlv_sgi     (dlv_sgi)
);

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   online_cnt;
  logic         trig_we;
  logic [2:0]   trig_req;
  logic [31:0]  trig_wdata;
  logic         win_valid, win_write, win_set;
  logic [2:0]   win_cpu;
  logic [3:0]   win_offset;
  logic [31:0]  win_wdata;
  logic [31:0]  win_rdata;
  logic         win_changed;
  logic [127:0] pend;
  logic [7:0]   dlv_valid, dlv_ready;
  logic [31:0]  dlv_sgi;
  logic [23:0]  dlv_src;

  int checks = 0;
  int failures = 0;
  logic [127:0] exp_p;
  logic [9:0]   exp_q [$];

  always #2.5 clk = ~clk;

  sgi_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt),
    .trig_we(trig_we), .trig_req(trig_req), .trig_wdata(trig_wdata),
    .win_valid(win_valid), .win_write(win_write), .win_set(win_set),
    .win_cpu(win_cpu), .win_offset(win_offset), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .win_changed(win_changed), .pend(pend),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_sgi(dlv_sgi), .dlv_src(dlv_src)
  );

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic trig(input logic [2:0] req, input logic [1:0] mode,
                      input logic [7:0] list, input logic [3:0] sgi);
    @(negedge clk);
    trig_we    = 1'b1;
    trig_req   = req;
    trig_wdata = {6'd0, mode, list, 12'd0, sgi};
    @(negedge clk);
    trig_we    = 1'b0;
  endtask

  task automatic win_wr(input logic [2:0] cpu, input logic set, input logic [3:0] off,
                        input logic [31:0] data);
    @(negedge clk);
    win_valid = 1'b1; win_write = 1'b1; win_set = set;
    win_cpu = cpu; win_offset = off; win_wdata = data;
    @(negedge clk);
    win_valid = 1'b0; win_write = 1'b0;
  endtask

  task automatic win_rd(input logic [2:0] cpu, input logic set, input logic [3:0] off,
                        output logic [31:0] data);
    win_cpu = cpu; win_offset = off; win_set = set;
    #1;
    data = win_rdata;
  endtask

  // Scoreboard monitor: every accepted delivery pops one expected item
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int t = 0; t < 8; t++) begin
        if (rst_n && dlv_valid[t] && dlv_ready[t]) begin
          logic [9:0] got;
          got = {3'(t), dlv_sgi[t*4 +: 4], dlv_src[t*3 +: 3]};
          if (exp_q.size() == 0) chk(128'(got), 128'h3ff, "R9 unexpected delivery");
          else chk(128'(got), 128'(exp_q.pop_front()), "R9 delivery order");
        end
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; online_cnt = 4'd8;
    trig_we = 1'b0; trig_req = '0; trig_wdata = '0;
    win_valid = 1'b0; win_write = 1'b0; win_set = 1'b0;
    win_cpu = '0; win_offset = '0; win_wdata = '0; dlv_ready = '0;
    exp_p = '0;
    repeat (3) @(negedge clk);
    chk(pend, 0, "R10 pend in reset");
    chk(128'(dlv_valid), 0, "R10 dlv_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    win_rd(3'd0, 1'b1, 4'd0, rd);
    chk(128'(rd), 0, "R10 window empty after reset");

    // R1 mode 0 explicit list, R5 source bit
    trig(3'd1, 2'd0, 8'h05, 4'd5);
    exp_p[0*16+5] = 1'b1; exp_p[2*16+5] = 1'b1;
    chk(pend, exp_p, "R1 R5 mode0 list targets");
    win_rd(3'd0, 1'b1, 4'd5, rd);
    chk(128'(rd), 128'h0000_0200, "R6 set window read offset 5");
    win_rd(3'd0, 1'b0, 4'd6, rd);
    chk(128'(rd), 128'h0000_0200, "R6 clear window read offset 6");
    win_rd(3'd2, 1'b1, 4'd4, rd);
    chk(128'(rd), 128'h0000_0200, "R5 target 2 source bitmap");

    trig(3'd3, 2'd0, 8'h00, 4'd7);
    chk(pend, exp_p, "R1 empty list no effect");
    trig(3'd3, 2'd3, 8'hFF, 4'd7);
    chk(pend, exp_p, "R4 reserved mode no effect");

    // R2 all others among four online
    online_cnt = 4'd4;
    trig(3'd2, 2'd1, 8'hFF, 4'd3);
    exp_p[0*16+3] = 1'b1; exp_p[1*16+3] = 1'b1; exp_p[3*16+3] = 1'b1;
    chk(pend, exp_p, "R2 mode1 others online");
    online_cnt = 4'd8;

    trig(3'd6, 2'd2, 8'h01, 4'd15);
    exp_p[6*16+15] = 1'b1;
    chk(pend, exp_p, "R3 mode2 self only");

    // R7 / R8 window edits on processor 7
    win_wr(3'd7, 1'b1, 4'd8, 32'h0081_0001);
    chk(128'(win_changed), 1, "R8 pulse on changing set");
    exp_p[7*16+8] = 1'b1; exp_p[7*16+10] = 1'b1;
    chk(pend, exp_p, "R7 set window pending");
    win_rd(3'd7, 1'b1, 4'd8, rd);
    chk(128'(rd), 128'h0081_0001, "R7 set window contents");
    win_wr(3'd7, 1'b1, 4'd8, 32'h0081_0001);
    chk(128'(win_changed), 0, "R8 no pulse on redundant set");
    win_wr(3'd7, 1'b0, 4'd9, 32'h0001_0001);
    chk(128'(win_changed), 1, "R8 pulse on changing clear");
    exp_p[7*16+8] = 1'b0;
    chk(pend, exp_p, "R7 clear window pending");
    win_rd(3'd7, 1'b0, 4'd8, rd);
    chk(128'(rd), 128'h0080_0000, "R7 clear window contents");
    win_wr(3'd7, 1'b0, 4'd9, 32'h0001_0001);
    chk(128'(win_changed), 0, "R8 no pulse on redundant clear");

    // R9 delivery order on target 0
    win_wr(3'd0, 1'b1, 4'd4, 32'h0000_1100);
    win_rd(3'd0, 1'b1, 4'd4, rd);
    chk(128'(rd), 128'h0000_1300, "R7 set merges bitmap");
    chk(128'(dlv_valid[0]), 1, "R9 offer valid");
    chk(128'(dlv_sgi[3:0]), 3, "R9 lowest interrupt first");
    chk(128'(dlv_src[2:0]), 2, "R9 lowest source first");
    exp_q.push_back({3'd0, 4'd3, 3'd2});
    exp_q.push_back({3'd0, 4'd5, 3'd0});
    exp_q.push_back({3'd0, 4'd5, 3'd1});
    exp_q.push_back({3'd0, 4'd5, 3'd4});
    @(negedge clk);
    dlv_ready[0] = 1'b1;
    repeat (4) @(negedge clk);
    dlv_ready[0] = 1'b0;
    #3;
    exp_p[0*16+3] = 1'b0; exp_p[0*16+5] = 1'b0;
    chk(pend, exp_p, "R9 drained pending cleared");
    chk(128'(dlv_valid[0]), 0, "R9 offer dropped when empty");
    chk(128'(exp_q.size()), 0, "R9 all expected deliveries seen");

    // R5 a second requester adds its own bit
    trig(3'd4, 2'd0, 8'h01, 4'd5);
    exp_p[0*16+5] = 1'b1;
    win_rd(3'd0, 1'b1, 4'd5, rd);
    chk(128'(rd), 128'h0000_1000, "R5 requester 4 bit recorded");

    // R11 trigger set beats window clear in same cycle
    @(negedge clk);
    trig_we = 1'b1; trig_req = 3'd4; trig_wdata = {6'd0, 2'd2, 8'd0, 12'd0, 4'd1};
    win_valid = 1'b1; win_write = 1'b1; win_set = 1'b0;
    win_cpu = 3'd4; win_offset = 4'd0; win_wdata = 32'h0000_1000;
    @(negedge clk);
    trig_we = 1'b0; win_valid = 1'b0; win_write = 1'b0;
    exp_p[4*16+1] = 1'b1;
    chk(pend, exp_p, "R11 set wins pending");
    win_rd(3'd4, 1'b0, 4'd0, rd);
    chk(128'(rd), 128'h0000_1000, "R11 set wins bitmap");

    // R10 reset in mid run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pend, 0, "R10 pend cleared by reset");
    chk(128'(dlv_valid), 0, "R10 offers cleared by reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule